// File: doc/BRIEF.md
# Request Completion Tracker

This block follows a single memory-card command request inside a host controller from issue to completion. When a request is issued it receives the command's attributes (busy signalling, data present, multi-block, write direction, stream mode and DMA or PIO transfer). From these it derives the set of completion events the request must wait for, opens those events and all error events in the interrupt mask, and clears its record of seen events.

While the request is active, raw single-cycle event pulses from the controller datapath are collected into a sticky seen register. They are also latched into a flag register that software clears by writing ones. The request completes successfully once every waited event has been seen. Any error event aborts it at once, and the error is classed as a timeout or a generic failure. Events that arrive with no request active are reported as spurious and otherwise discarded. A second issue while a request is active is refused.

Top module: `rct_req_tracker`

## Requirements
- R1: After reset the block is idle: `active`, `wait_set`, `seen_set`, `flags` and all pulse outputs are 0, and `irq_mask` is all ones.
- R2: Event bit positions are: 0 command-response end, 1 programming done, 2 automatic stop done, 3 transfer done, 4 DMA end, 5 TX FIFO request, 6 RX FIFO request, 7 response CRC error, 8 read CRC error, 9 write CRC error, 10 response timeout, 11 read timeout. An accepted issue sets `active` on the next clock. The new `wait_set` always contains bit 0, and it contains bit 1 when `cmd_busy` is set or when a data transfer is a write.
- R3: For a data transfer, `multi_blk` adds bit 2, and a non-stream transfer adds bit 3 (stream mode does not). Without `has_data`, bits 2 to 6 are not in the wait set.
- R4: For a data transfer, DMA mode adds bit 4. PIO mode adds bit 5 for a write and bit 6 for a read.
- R5: While a request is active, `irq_mask` equals the inverse of the OR of the error bits (7 to 11) and `wait_set`. When idle it is all ones.
- R6: Events arriving while active are ORed into `seen_set`. When the seen set covers the wait set, `done_ok` pulses for one cycle on the clock that absorbs the last event, and `active` drops on that same clock.
- R7: Any error event while active ends the request on that clock with a one-cycle `done_err`. `err_timeout` pulses with it exactly when bit 10 or 11 was present. Error takes precedence over success in the same cycle.
- R8: Any event while idle pulses `spurious` on the next clock and changes neither `seen_set` nor `flags`.
- R9: `issue` while active pulses `reject` on the next clock and leaves `wait_set` unchanged. A completion in that same cycle still takes effect.
- R10: `flags` latches each event that arrives while active. Writing `flag_clr_bits` with `flag_clr_we` clears those bits, and a new event on the same bit in the same cycle wins over the clear.
- R11: On completion, by success or error, `wait_set` and `seen_set` return to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| issue | input | 1 | Issue pulse for a new request |
| cmd_busy | input | 1 | Command signals busy |
| has_data | input | 1 | Request carries a data transfer |
| multi_blk | input | 1 | Multi-block transfer with automatic stop |
| dir_write | input | 1 | Transfer direction is write |
| stream_mode | input | 1 | Stream transfer |
| use_dma | input | 1 | Data moved by DMA rather than PIO |
| ev_in | input | 12 | Raw event pulses |
| flag_clr_we | input | 1 | Flag clear strobe |
| flag_clr_bits | input | 12 | Flag bits to clear (write one to clear) |
| active | output | 1 | A request is in progress |
| wait_set | output | 12 | Events the request waits for |
| seen_set | output | 12 | Events seen during the request |
| irq_mask | output | 12 | Interrupt mask, 1 = masked |
| flags | output | 12 | Latched event flags |
| done_ok | output | 1 | Successful completion pulse |
| done_err | output | 1 | Error completion pulse |
| err_timeout | output | 1 | Error was a timeout, valid with done_err |
| reject | output | 1 | Issue refused because a request was active |
| spurious | output | 1 | Event arrived with no request active |

## Verification
The success check and the error check can both resolve on the same clock. This happens when one event pulse carries the last waited bit together with an error bit. The bench provokes it by sending the command-end and response-CRC bits in one cycle against a request that waits only for command end. It expects `done_err` without `done_ok` and with `err_timeout` low. The same overlap is also provoked between a refused issue and a completing event, and the bench expects both `reject` and `done_ok` to pulse.

// File: rtl/rct_pkg.sv
package rct_pkg;
   localparam int EV_W = 12;

   localparam int EV_CMD    = 0;
   localparam int EV_PROG   = 1;
   localparam int EV_STOP   = 2;
   localparam int EV_XFER   = 3;
   localparam int EV_DMA    = 4;
   localparam int EV_TXREQ  = 5;
   localparam int EV_RXREQ  = 6;
   localparam int EV_RSPCRC = 7;
   localparam int EV_RDCRC  = 8;
   localparam int EV_WRCRC  = 9;
   localparam int EV_RSPTMO = 10;
   localparam int EV_RDTMO  = 11;

   typedef logic [EV_W-1:0] ev_t;

   localparam ev_t TMO_BITS = ev_t'((1 << EV_RSPTMO) | (1 << EV_RDTMO));
   localparam ev_t ERR_BITS = ev_t'((1 << EV_RSPCRC) | (1 << EV_RDCRC) |
                                    (1 << EV_WRCRC)) | TMO_BITS;

   typedef struct packed {
      logic busy;
      logic data;
      logic multi;
      logic write;
      logic stream;
      logic dma;
   } req_attr_t;
endpackage

// File: rtl/rct_waitset.sv
module rct_waitset
   import rct_pkg::*;
#(
   parameter int HAS_DMA = 1
) (
   input  req_attr_t attr,
   output ev_t       wait_new
);
   logic dma_sel;

   generate
      if (HAS_DMA != 0 && HAS_DMA != 1) begin : g_bad
         $error("rct_waitset: HAS_DMA must be 0 or 1");
      end
      if (HAS_DMA == 1) begin : g_dma
         assign dma_sel = attr.dma;
      end else begin : g_pio
         assign dma_sel = 1'b0;
      end
   endgenerate

   always_comb begin
      wait_new         = '0;
      wait_new[EV_CMD] = 1'b1;
      if (attr.busy)
         wait_new[EV_PROG] = 1'b1;
      if (attr.data) begin
         if (attr.write)
            wait_new[EV_PROG] = 1'b1;
         if (attr.multi)
            wait_new[EV_STOP] = 1'b1;
         if (!attr.stream)
            wait_new[EV_XFER] = 1'b1;
         if (dma_sel)
            wait_new[EV_DMA] = 1'b1;
         else if (attr.write)
            wait_new[EV_TXREQ] = 1'b1;
         else
            wait_new[EV_RXREQ] = 1'b1;
      end
   end
endmodule

// File: rtl/rct_seen.sv
module rct_seen
   import rct_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  ev_t  ev_act,
   input  ev_t  wait_q,
   output ev_t  seen_q,
   output logic covered
);
   ev_t seen_next;

   assign seen_next = seen_q | ev_act;
   assign covered   = ((seen_next & wait_q) == wait_q);

   always_ff @(posedge clk) begin
      if (!rst_n)
         seen_q <= '0;
      else if (clr)
         seen_q <= '0;
      else
         seen_q <= seen_next;
   end
endmodule

// File: rtl/rct_w1c_flags.sv
module rct_w1c_flags #(
   parameter int W = 12
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] set_bits,
   input  logic         clr_we,
   input  logic [W-1:0] clr_bits,
   output logic [W-1:0] flags_q
);
   generate
      for (genvar i = 0; i < W; i++) begin : g_bit
         always_ff @(posedge clk) begin
            if (!rst_n)
               flags_q[i] <= 1'b0;
            else if (set_bits[i])
               flags_q[i] <= 1'b1;
            else if (clr_we && clr_bits[i])
               flags_q[i] <= 1'b0;
         end
      end
   endgenerate
endmodule

// File: rtl/rct_req_tracker.sv
module rct_req_tracker
   import rct_pkg::*;
#(
   parameter int HAS_DMA = 1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            issue,
   input  logic            cmd_busy,
   input  logic            has_data,
   input  logic            multi_blk,
   input  logic            dir_write,
   input  logic            stream_mode,
   input  logic            use_dma,
   input  logic [EV_W-1:0] ev_in,
   input  logic            flag_clr_we,
   input  logic [EV_W-1:0] flag_clr_bits,
   output logic            active,
   output logic [EV_W-1:0] wait_set,
   output logic [EV_W-1:0] seen_set,
   output logic [EV_W-1:0] irq_mask,
   output logic [EV_W-1:0] flags,
   output logic            done_ok,
   output logic            done_err,
   output logic            err_timeout,
   output logic            reject,
   output logic            spurious
);
   localparam ev_t MASK_ALL = '1;

   req_attr_t attr;
   ev_t       wait_new, wait_q, mask_q, ev_act, seen_q;
   logic      active_q, issue_ok, err_hit, ok_hit, finish, covered;
   logic      ok_q, err_q, tmo_q, rej_q, spur_q;

   assign attr = '{busy: cmd_busy, data: has_data, multi: multi_blk,
                   write: dir_write, stream: stream_mode, dma: use_dma};

   rct_waitset #(.HAS_DMA(HAS_DMA)) u_waitset (
      .attr     (attr),
      .wait_new (wait_new)
   );

   assign issue_ok = issue & ~active_q;
   assign ev_act   = active_q ? ev_in : '0;
   assign err_hit  = |(ev_act & ERR_BITS);
   assign ok_hit   = active_q & ~err_hit & covered;
   assign finish   = err_hit | ok_hit;

   rct_seen u_seen (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (issue_ok | finish),
      .ev_act  (ev_act),
      .wait_q  (wait_q),
      .seen_q  (seen_q),
      .covered (covered)
   );

   rct_w1c_flags #(.W(EV_W)) u_flags (
      .clk      (clk),
      .rst_n    (rst_n),
      .set_bits (ev_act),
      .clr_we   (flag_clr_we),
      .clr_bits (flag_clr_bits),
      .flags_q  (flags)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         active_q <= 1'b0;
         wait_q   <= '0;
         mask_q   <= MASK_ALL;
      end else if (issue_ok) begin
         active_q <= 1'b1;
         wait_q   <= wait_new;
         mask_q   <= ~(ERR_BITS | wait_new);
      end else if (finish) begin
         active_q <= 1'b0;
         wait_q   <= '0;
         mask_q   <= MASK_ALL;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ok_q   <= 1'b0;
         err_q  <= 1'b0;
         tmo_q  <= 1'b0;
         rej_q  <= 1'b0;
         spur_q <= 1'b0;
      end else begin
         ok_q   <= ok_hit;
         err_q  <= err_hit;
         tmo_q  <= err_hit & (|(ev_act & TMO_BITS));
         rej_q  <= issue & active_q;
         spur_q <= ~active_q & (|ev_in);
      end
   end

   assign active      = active_q;
   assign wait_set    = wait_q;
   assign seen_set    = seen_q;
   assign irq_mask    = mask_q;
   assign done_ok     = ok_q;
   assign done_err    = err_q;
   assign err_timeout = tmo_q;
   assign reject      = rej_q;
   assign spurious    = spur_q;
endmodule

// File: rtl/rct_req_tracker_chk.sv
module rct_req_tracker_chk
   import rct_pkg::*;
(
   input logic      clk,
   input logic      rst_n,
   input logic      active,
   input ev_t       wait_set,
   input ev_t       seen_set,
   input ev_t       irq_mask,
   input logic      done_ok,
   input logic      done_err,
   input logic      err_timeout,
   input logic      reject,
   input logic      spurious
);
   AST_WAIT_HAS_CMD: assert property (@(posedge clk) disable iff (!rst_n)
      active |-> wait_set[EV_CMD]); // R2

   AST_MASK_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
      active |-> (irq_mask == ~(ERR_BITS | wait_set))); // R5

   AST_MASK_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !active |-> (irq_mask == '1)); // R5

   AST_OK_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
      done_ok |-> !active); // R6

   AST_ERR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(done_ok && done_err)); // R7

   AST_TMO_WITH_ERR: assert property (@(posedge clk) disable iff (!rst_n)
      err_timeout |-> done_err); // R7

   AST_SPUR_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      spurious |-> $stable(seen_set)); // R8

   AST_REJECT_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
      (reject && active) |-> $stable(wait_set)); // R9

   AST_IDLE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      !active |-> (wait_set == '0 && seen_set == '0)); // R11
endmodule

bind rct_req_tracker rct_req_tracker_chk u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .active      (active),
   .wait_set    (wait_set),
   .seen_set    (seen_set),
   .irq_mask    (irq_mask),
   .done_ok     (done_ok),
   .done_err    (done_err),
   .err_timeout (err_timeout),
   .reject      (reject),
   .spurious    (spurious)
);

// File: tb/tb_rct_req_tracker.sv
`timescale 1ns/1ps
module tb_rct_req_tracker;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        issue = 1'b0, cmd_busy = 1'b0, has_data = 1'b0, multi_blk = 1'b0;
   logic        dir_write = 1'b0, stream_mode = 1'b0, use_dma = 1'b0;
   logic [11:0] ev_in = '0, flag_clr_bits = '0;
   logic        flag_clr_we = 1'b0;
   logic        active, done_ok, done_err, err_timeout, reject, spurious;
   logic [11:0] wait_set, seen_set, irq_mask, flags;

   int n_chk = 0, n_fail = 0;
   bit finished = 0;

   localparam logic [11:0] ERR = 12'hF80;

   always #4 clk = ~clk;

   rct_req_tracker dut (
      .clk(clk), .rst_n(rst_n), .issue(issue), .cmd_busy(cmd_busy),
      .has_data(has_data), .multi_blk(multi_blk), .dir_write(dir_write),
      .stream_mode(stream_mode), .use_dma(use_dma), .ev_in(ev_in),
      .flag_clr_we(flag_clr_we), .flag_clr_bits(flag_clr_bits),
      .active(active), .wait_set(wait_set), .seen_set(seen_set),
      .irq_mask(irq_mask), .flags(flags), .done_ok(done_ok),
      .done_err(done_err), .err_timeout(err_timeout), .reject(reject),
      .spurious(spurious)
   );

   task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s: got %0h expected %0h", tag, got, exp);
      end
   endtask

   // one clock: drive at negedge, sample at the following negedge
   task automatic cyc(input logic iss, input logic [5:0] a, input logic [11:0] ev,
                      input logic cwe, input logic [11:0] cb);
      issue = iss;
      {cmd_busy, has_data, multi_blk, dir_write, stream_mode, use_dma} = a;
      ev_in = ev; flag_clr_we = cwe; flag_clr_bits = cb;
      @(negedge clk);
      issue = 0; {cmd_busy, has_data, multi_blk, dir_write, stream_mode, use_dma} = '0;
      ev_in = '0; flag_clr_we = 0; flag_clr_bits = '0;
   endtask

   task automatic clear_flags();
      cyc(0, 6'b0, 12'h0, 1, 12'hFFF);
   endtask

   task automatic t_reset();
      chk("R1 active", active, 0);
      chk("R1 wait", wait_set, 0);
      chk("R1 seen", seen_set, 0);
      chk("R1 mask", irq_mask, 12'hFFF);
      chk("R1 flags", flags, 0);
      chk("R1 pulses", {done_ok, done_err, err_timeout, reject, spurious}, 0);
   endtask

   task automatic t_nodata();
      cyc(1, 6'b000000, 0, 0, 0);
      chk("R2 active", active, 1);
      chk("R2 wait nodata", wait_set, 12'h001);
      chk("R5 mask active", irq_mask, ~(ERR | 12'h001) & 12'hFFF);
      cyc(0, 0, 12'h001, 0, 0);
      chk("R6 done_ok", done_ok, 1);
      chk("R6 active drops", active, 0);
      chk("R11 wait cleared", wait_set, 0);
      chk("R11 seen cleared", seen_set, 0);
      chk("R5 mask idle", irq_mask, 12'hFFF);
      chk("R10 flag latched", flags, 12'h001);
      cyc(0, 0, 0, 1, 12'h001);
      chk("R10 w1c", flags, 0);
      chk("R6 pulse one cycle", done_ok, 0);
   endtask

   task automatic t_busy();
      // attr order: busy,data,multi,write,stream,dma
      cyc(1, 6'b100000, 0, 0, 0);
      chk("R2 wait busy", wait_set, 12'h003);
      cyc(0, 0, 12'h001, 0, 0);
      chk("R6 partial not done", done_ok, 0);
      chk("R6 seen partial", seen_set, 12'h001);
      cyc(0, 0, 12'h002, 0, 0);
      chk("R6 done busy", done_ok, 1);
      clear_flags();
   endtask

   task automatic t_pio_read_multi();
      cyc(1, 6'b011000, 0, 0, 0);
      chk("R3 R4 wait pio read multi", wait_set, 12'h04D);
      cyc(0, 0, 12'h00D, 0, 0);
      chk("R6 not done yet", {done_ok, active}, 2'b01);
      cyc(0, 0, 12'h040, 0, 0);
      chk("R4 rx completes", done_ok, 1);
      clear_flags();
   endtask

   task automatic t_dma_write_stream();
      cyc(1, 6'b010111, 0, 0, 0);
      chk("R3 R4 wait dma write stream", wait_set, 12'h013);
      cyc(0, 0, 12'h800, 0, 0);
      chk("R7 err", {done_err, done_ok, active}, 3'b100);
      chk("R7 timeout class", err_timeout, 1);
      chk("R11 seen after err", seen_set, 0);
      clear_flags();
   endtask

   task automatic t_err_vs_ok();
      cyc(1, 6'b000000, 0, 0, 0);
      cyc(0, 0, 12'h081, 0, 0);
      chk("R7 err wins", {done_err, done_ok}, 2'b10);
      chk("R7 crc is failure", err_timeout, 0);
      clear_flags();
   endtask

   task automatic t_pio_write_reject();
      cyc(1, 6'b010100, 0, 0, 0);
      chk("R4 wait pio write", wait_set, 12'h02B);
      cyc(1, 6'b000000, 0, 0, 0);
      chk("R9 reject", reject, 1);
      chk("R9 wait kept", wait_set, 12'h02B);
      cyc(1, 6'b000000, 12'h02B, 0, 0);
      chk("R9 reject with completion", {reject, done_ok, active}, 3'b110);
      clear_flags();
   endtask

   task automatic t_spurious();
      cyc(0, 0, 12'h401, 0, 0);
      chk("R8 spurious", spurious, 1);
      chk("R8 flags untouched", flags, 0);
      chk("R8 seen untouched", seen_set, 0);
      chk("R8 still idle", active, 0);
   endtask

   task automatic t_flag_race();
      cyc(1, 6'b100000, 0, 0, 0);
      cyc(0, 0, 12'h001, 0, 0);
      chk("R10 set", flags, 12'h001);
      cyc(0, 0, 12'h001, 1, 12'h001);
      chk("R10 set beats clear", flags, 12'h001);
      cyc(0, 0, 0, 1, 12'h001);
      chk("R10 cleared", flags, 0);
      cyc(0, 0, 12'h002, 0, 0);
      chk("R6 finish", done_ok, 1);
      clear_flags();
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      t_reset();
      t_nodata();
      t_busy();
      t_pio_read_multi();
      t_dma_write_stream();
      t_err_vs_ok();
      t_pio_write_reject();
      t_spurious();
      t_flag_race();
      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      #(8 * 20000);
      if (!finished) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: got hang expected completion");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end
endmodule